// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block produces the SCL and SDA line timing for an I2C master. A byte-level engine hands it one command at a time: generate a START, shift one data bit, or generate a STOP. The block then drives open-drain style pull-down enables for both lines, and pulses a completion strobe when the bus condition has been fully formed. Every interval is counted in prescaled ticks, and one tick is 2^P functional clock cycles, with P running from 0 to 7. Four separate counts set the timing: SCL low time, SCL high time, the START/STOP setup-hold time, and the delay from an SCL falling edge to the SDA update.

Two timing words are held: one for the normal speed modes and one for high-speed mode. A mode input picks between them. The prescaler, the selected timing word and the glitch-filter widths are all captured only while the master is disabled, so a transfer always runs on one consistent setting. The filter widths are only stored and passed out to the input filters. The SCL line is sensed while the block releases it, so a slave that holds SCL low stretches the high phase. The sensed SDA level at the end of each high phase is returned as the received bit.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, and in the cycle after any clock edge at which `enable` is low, `sclLow`, `sdaLow` and `doneStrobe` are 0 and `cmdReady` is 0; disabling aborts any command in progress.
- R2: One count unit lasts 2^`prescale` clock cycles; a count N gives an interval of (N+1)·2^`prescale` cycles.
- R3: START (cmdOp 2'b01, accepted only with both lines released) pulls SDA low in the cycle after acceptance, keeps SCL released for SH+1 units, then pulls SCL low and pulses `doneStrobe`.
- R4: A data bit (cmdOp 2'b10, accepted only after START or a previous bit) keeps SCL low for LO+1 units, releases it for HI+1 units, then pulls it low again with `doneStrobe`, for a bit period of LO+HI+2 units.
- R5: In a data bit the SDA enable takes the value of `cmdBit` inverted after min(DV,LO)+1 units from the SCL falling edge, never later than SCL release.
- R6: STOP (cmdOp 2'b11, accepted after START or a bit) holds SCL low for LO+1 units, pulling SDA low after min(DV,LO)+1 units. It then releases SCL, waits SH+1 units and releases SDA with `doneStrobe`; SDA rises only in that final step.
- R7: While SCL is released by the block in a data-bit high phase or a STOP setup phase, every clock cycle with `sclIn` low is not counted; SCL is never pulled low in a cycle after `sclIn` was sampled low.
- R8: `rxBit` is the `sdaIn` level sampled at the clock edge that ends the SCL high phase of a data bit, valid while `doneStrobe` is high.
- R9: The timing word packs DV in bits [29:24], SH in [21:16], HI in [13:8] and LO in [5:0]; `hsMode` high selects `timingHs`, low selects `timingNorm`.
- R10: `prescale`, `hsMode`, both timing words and `filtCfg` are captured only while `enable` is low; changes while enabled have no effect on timing or on the filter outputs.
- R11: `sdaFilt` carries `filtCfg`[27:24] and `sclFilt` carries `filtCfg`[19:16] as captured.
- R12: A command not valid in the present bus state (a bit, STOP or code 2'b00 when idle; START or 2'b00 after START) is dropped with no line change and no `doneStrobe`.
- R13: `cmdReady` is high only while enabled and idle or holding SCL low between commands; `doneStrobe` is a one-cycle pulse during which `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; low captures settings and idles the lines |
| hsMode | input | 1 | Selects the high-speed timing word |
| prescale | input | 3 | Tick divider exponent P |
| timingNorm | input | 32 | Timing word for normal modes |
| timingHs | input | 32 | Timing word for high-speed mode |
| filtCfg | input | 32 | Glitch-filter width fields |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 01 START, 10 data bit, 11 STOP |
| cmdBit | input | 1 | Bit value to drive for a data-bit command |
| cmdReady | output | 1 | Command accepted when high with cmdValid |
| sclIn | input | 1 | Sensed SCL level |
| sdaIn | input | 1 | Sensed SDA level |
| sclLow | output | 1 | Pull SCL low when 1 |
| sdaLow | output | 1 | Pull SDA low when 1 |
| doneStrobe | output | 1 | One-cycle pulse at end of a command |
| rxBit | output | 1 | SDA sampled at end of SCL high |
| sclFilt | output | 4 | Captured SCL filter width |
| sdaFilt | output | 4 | Captured SDA filter width |

## Verification
The clock edge at which a command is accepted is taken as edge 0. Every line change and the completion pulse land on edge k·2^P for a whole number k given by the count formulas: START ends at SH+1, an SDA update at min(DV,LO)+1, SCL release at LO+1, a bit ends at LO+HI+2 and a STOP at LO+SH+2, with stretch cycles added after release. The bench samples on the falling clock edge after each rising edge, so an output registered at edge k is first seen at index k. It compares the first change index of each line, and the pulse index, with these values computed from the table's counts.

// File: rtl/i2c_timer_pkg.sv
package i2c_timer_pkg;
  // spacing of the four count fields inside a timing word (LO, HI, SH, DV)
  localparam int FIELD_STRIDE = 8;
  localparam int NUM_FIELDS   = 4;
  localparam int FLD_LO = 0;
  localparam int FLD_HI = 1;
  localparam int FLD_SH = 2;
  localparam int FLD_DV = 3;
  localparam int SCL_FLT_LSB = 16;
  localparam int SDA_FLT_LSB = 24;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_START = 2'b01,
    OP_BIT   = 2'b10,
    OP_STOP  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_HOLD = 2'b10
  } limSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HELD,
    ST_BIT_LOW,
    ST_BIT_HIGH,
    ST_STOP_LOW,
    ST_STOP_SETUP
  } state_e;

  // control -> datapath
  typedef struct packed {
    logic    clear;
    logic    run;
    limSel_e sel;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic phaseEnd;
    logic dvHit;
  } dpStatus_t;
endpackage

// File: rtl/i2c_timer_datapath.sv
module i2c_timer_datapath
  import i2c_timer_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int PRE_W  = 3,
  parameter int FLT_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hsMode,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [WORD_W-1:0] timingNorm,
  input  logic [WORD_W-1:0] timingHs,
  input  logic [WORD_W-1:0] filtCfg,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         stat,
  output logic [FLT_W-1:0]  sclFilt,
  output logic [FLT_W-1:0]  sdaFilt
);
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  logic [WORD_W-1:0]    selWord;
  logic [CNT_W-1:0]     fieldLat [NUM_FIELDS];
  logic [PRE_W-1:0]     preLat;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preMask;
  logic [CNT_W-1:0]     phaseCnt;
  logic [CNT_W-1:0]     limit;
  logic                 tick;
  logic                 unusedCfgBits;

  assign selWord       = hsMode ? timingHs : timingNorm;
  assign unusedCfgBits = ^{timingNorm, timingHs, filtCfg};

  // settings are captured only while the master is disabled
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        fieldLat[f] <= '0;
      else if (!enable) fieldLat[f] <= selWord[f*FIELD_STRIDE +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLat  <= '0;
      sclFilt <= '0;
      sdaFilt <= '0;
    end else if (!enable) begin
      preLat  <= prescale;
      sclFilt <= filtCfg[SCL_FLT_LSB +: FLT_W];
      sdaFilt <= filtCfg[SDA_FLT_LSB +: FLT_W];
    end
  end

  // power-of-two tick divider
  assign preMask = ~({PRE_CNT_W{1'b1}} << preLat);
  assign tick    = ctl.run && (preCnt == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          preCnt <= '0;
    else if (ctl.clear) preCnt <= '0;
    else if (ctl.run)   preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  // phase counter, counts ticks since the phase began
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phaseCnt <= '0;
    else if (ctl.clear) phaseCnt <= '0;
    else if (tick)      phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    case (ctl.sel)
      SEL_HIGH: limit = fieldLat[FLD_HI];
      SEL_HOLD: limit = fieldLat[FLD_SH];
      default:  limit = fieldLat[FLD_LO];
    endcase
  end

  assign stat.phaseEnd = tick && (phaseCnt == limit);
  assign stat.dvHit    = tick && (phaseCnt == fieldLat[FLD_DV]);
endmodule

// File: rtl/i2c_timer_control.sv
module i2c_timer_control
  import i2c_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       cmdReady,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       doneStrobe,
  output logic       rxBit
);
  state_e state;
  logic   accept;
  logic   bitQ;
  logic   busy;
  logic   releasedPhase;
  op_e    op;

  assign op       = op_e'(cmdOp);
  assign cmdReady = enable && (state == ST_IDLE || state == ST_HELD);
  assign accept   = cmdValid && cmdReady;

  assign busy          = !(state == ST_IDLE || state == ST_HELD);
  assign releasedPhase = (state == ST_BIT_HIGH) || (state == ST_STOP_SETUP);

  always_comb begin
    ctl.clear = !enable || accept || stat.phaseEnd;
    ctl.run   = enable && busy && !(releasedPhase && !sclIn);
    case (state)
      ST_BIT_HIGH:             ctl.sel = SEL_HIGH;
      ST_START, ST_STOP_SETUP: ctl.sel = SEL_HOLD;
      default:                 ctl.sel = SEL_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sclLow     <= 1'b0;
      sdaLow     <= 1'b0;
      doneStrobe <= 1'b0;
      rxBit      <= 1'b0;
      bitQ       <= 1'b0;
    end else if (!enable) begin
      state      <= ST_IDLE;
      sclLow     <= 1'b0;
      sdaLow     <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && op == OP_START) begin
            sdaLow <= 1'b1;
            state  <= ST_START;
          end
        end
        ST_START: begin
          if (stat.phaseEnd) begin
            sclLow     <= 1'b1;
            doneStrobe <= 1'b1;
            state      <= ST_HELD;
          end
        end
        ST_HELD: begin
          if (accept && op == OP_BIT) begin
            bitQ  <= cmdBit;
            state <= ST_BIT_LOW;
          end else if (accept && op == OP_STOP) begin
            state <= ST_STOP_LOW;
          end
        end
        ST_BIT_LOW: begin
          if (stat.dvHit || stat.phaseEnd) sdaLow <= !bitQ;
          if (stat.phaseEnd) begin
            sclLow <= 1'b0;
            state  <= ST_BIT_HIGH;
          end
        end
        ST_BIT_HIGH: begin
          if (stat.phaseEnd) begin
            sclLow     <= 1'b1;
            rxBit      <= sdaIn;
            doneStrobe <= 1'b1;
            state      <= ST_HELD;
          end
        end
        ST_STOP_LOW: begin
          if (stat.dvHit || stat.phaseEnd) sdaLow <= 1'b1;
          if (stat.phaseEnd) begin
            sclLow <= 1'b0;
            state  <= ST_STOP_SETUP;
          end
        end
        ST_STOP_SETUP: begin
          if (stat.phaseEnd) begin
            sdaLow     <= 1'b0;
            doneStrobe <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_timer_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int PRE_W  = 3,
  parameter int FLT_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hsMode,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [WORD_W-1:0] timingNorm,
  input  logic [WORD_W-1:0] timingHs,
  input  logic [WORD_W-1:0] filtCfg,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              cmdBit,
  output logic              cmdReady,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  output logic              doneStrobe,
  output logic              rxBit,
  output logic [FLT_W-1:0]  sclFilt,
  output logic [FLT_W-1:0]  sdaFilt
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  i2c_timer_datapath #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W),
    .FLT_W (FLT_W),
    .WORD_W(WORD_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .hsMode    (hsMode),
    .prescale  (prescale),
    .timingNorm(timingNorm),
    .timingHs  (timingHs),
    .filtCfg   (filtCfg),
    .ctl       (ctl),
    .stat      (stat),
    .sclFilt   (sclFilt),
    .sdaFilt   (sdaFilt)
  );

  i2c_timer_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdBit    (cmdBit),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .stat      (stat),
    .ctl       (ctl),
    .cmdReady  (cmdReady),
    .sclLow    (sclLow),
    .sdaLow    (sdaLow),
    .doneStrobe(doneStrobe),
    .rxBit     (rxBit)
  );
endmodule

// File: rtl/i2c_bit_timer_checks.sv
module i2c_bit_timer_checks #(
  parameter int PRE_W  = 3,
  parameter int FLT_W  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              hsMode,
  input logic [PRE_W-1:0]  prescale,
  input logic [WORD_W-1:0] timingNorm,
  input logic [WORD_W-1:0] timingHs,
  input logic [WORD_W-1:0] filtCfg,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              cmdBit,
  input logic              cmdReady,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sclLow,
  input logic              sdaLow,
  input logic              doneStrobe,
  input logic              rxBit,
  input logic [FLT_W-1:0]  sclFilt,
  input logic [FLT_W-1:0]  sdaFilt
);
  logic unusedChk;
  assign unusedChk = ^{hsMode, prescale, timingNorm, timingHs, filtCfg, cmdBit, sdaIn, rxBit};

  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclLow && !sdaLow && !doneStrobe));

  // SDA may fall under a released SCL only as a START
  assert_start_forms_sda_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaLow) && !sclLow && $past(!sclLow))
      |-> $past(cmdValid && cmdReady && cmdOp == i2c_timer_pkg::OP_START));

  // SDA may rise under a released SCL only as the end of a STOP
  assert_stop_ends_sda_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaLow) && !sclLow && $past(!sclLow) && $past(enable)) |-> doneStrobe);

  assert_no_pull_during_stretch_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclLow) |-> $past(sclIn));

  assert_filters_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> ($stable(sclFilt) && $stable(sdaFilt)));

  assert_done_single_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  assert_done_when_ready_R13: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && enable) |-> cmdReady);
endmodule

bind i2c_bit_timer i2c_bit_timer_checks #(
  .PRE_W (PRE_W),
  .FLT_W (FLT_W),
  .WORD_W(WORD_W)
) u_checks (.*);

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        hsMode = 1'b0;
  logic [2:0]  prescale = '0;
  logic [31:0] timingNorm = '0;
  logic [31:0] timingHs = '0;
  logic [31:0] filtCfg = '0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic        cmdBit = 1'b0;
  logic        cmdReady;
  logic        sclIn, sdaIn;
  logic        sclLow, sdaLow, doneStrobe, rxBit;
  logic [3:0]  sclFilt, sdaFilt;
  logic        stretchHold = 1'b0;
  logic        slaveSdaLow = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;

  localparam logic [1:0] START = 2'b01, DBIT = 2'b10, STOP = 2'b11;

  always #2 clk = ~clk;

  // open-drain bus model
  assign sclIn = !sclLow && !stretchHold;
  assign sdaIn = !sdaLow && !slaveSdaLow;

  i2c_bit_timer i_i2c_bit_timer (.*);

  typedef struct packed {
    logic [2:0] pre;
    logic [5:0] lo, hi, sh, dv;
    logic [7:0] eStart, eSda, eScl, eDone, eStopScl, eStopDone;
  } vec_t;

  // expected indices, counted in clock edges from the accept edge
  localparam vec_t VECS [6] = '{
    '{3'd0, 6'd5, 6'd2, 6'd2, 6'd1, 8'd3,  8'd2, 8'd6,  8'd9,  8'd6,  8'd9},
    '{3'd1, 6'd3, 6'd1, 6'd1, 6'd0, 8'd4,  8'd2, 8'd8,  8'd12, 8'd8,  8'd12},
    '{3'd2, 6'd2, 6'd1, 6'd3, 6'd1, 8'd16, 8'd8, 8'd12, 8'd20, 8'd12, 8'd28},
    '{3'd0, 6'd2, 6'd0, 6'd0, 6'd5, 8'd1,  8'd3, 8'd3,  8'd4,  8'd3,  8'd4},
    '{3'd3, 6'd1, 6'd1, 6'd0, 6'd0, 8'd8,  8'd8, 8'd16, 8'd32, 8'd16, 8'd24},
    '{3'd0, 6'd0, 6'd0, 6'd0, 6'd0, 8'd1,  8'd1, 8'd1,  8'd2,  8'd1,  8'd2}
  };

  function automatic logic [31:0] mkWord(input logic [5:0] lo, hi, sh, dv);
    return {2'b00, dv, 2'b00, sh, 2'b00, hi, 2'b00, lo};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [2:0] p, input logic [31:0] norm, input logic [31:0] hs,
                       input logic hsSel);
    @(negedge clk);
    enable = 1'b0;
    prescale = p; timingNorm = norm; timingHs = hs; hsMode = hsSel;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic runCmd(input logic [1:0] op, input logic b, input int stretch,
                        output int tSda, output int tScl, output int tDone,
                        output logic rx, output logic rdyBusy);
    int left;
    logic pSda, pScl;
    tSda = -1; tScl = -1; tDone = -1; rx = 1'b0; rdyBusy = 1'b0; left = stretch;
    @(negedge clk);
    cmdOp = op; cmdBit = b; cmdValid = 1'b1;
    pSda = sdaLow; pScl = sclLow;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int idx = 0; idx < 4000; idx++) begin
      if (sdaLow !== pSda && tSda < 0) tSda = idx;
      if (sclLow !== pScl && tScl < 0) tScl = idx;
      if (doneStrobe) begin
        tDone = idx;
        rx = rxBit;
        break;
      end
      if (cmdReady) rdyBusy = 1'b1;
      if (tScl >= 0 && !sclLow && left > 0) begin
        stretchHold = 1'b1;
        left--;
      end else begin
        stretchHold = 1'b0;
      end
      @(negedge clk);
    end
    stretchHold = 1'b0;
  endtask

  task automatic pulseCmd(input logic [1:0] op);
    @(negedge clk);
    cmdOp = op; cmdBit = 1'b1; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int ts, tc, td;
    logic rx, rb;
    int sawDone;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset sclLow", sclLow, 0);
    check("R1 reset sdaLow", sdaLow, 0);
    check("R1 reset done", doneStrobe, 0);
    check("R1 ready while disabled", cmdReady, 0);

    // table walk: START, bit 1, STOP under several timing settings (R2..R6, R13)
    for (int v = 0; v < 6; v++) begin
      setup(VECS[v].pre, mkWord(VECS[v].lo, VECS[v].hi, VECS[v].sh, VECS[v].dv),
            32'h0, 1'b0);
      runCmd(START, 1'b0, 0, ts, tc, td, rx, rb);
      check("R3 start sda index", ts, 0);
      check("R3 start scl index", tc, int'(VECS[v].eStart));
      check("R2 R3 start done index", td, int'(VECS[v].eStart));
      check("R13 ready low while busy", rb, 0);
      runCmd(DBIT, 1'b1, 0, ts, tc, td, rx, rb);
      check("R5 data-valid index", ts, int'(VECS[v].eSda));
      check("R4 scl release index", tc, int'(VECS[v].eScl));
      check("R2 R4 bit done index", td, int'(VECS[v].eDone));
      runCmd(STOP, 1'b0, 0, ts, tc, td, rx, rb);
      check("R6 stop scl release index", tc, int'(VECS[v].eStopScl));
      check("R6 stop done index", td, int'(VECS[v].eStopDone));
      check("R6 lines released after stop", {sclLow, sdaLow}, 0);
    end

    // R7: clock stretching adds the held cycles to the high phase
    setup(3'd0, mkWord(6'd5, 6'd2, 6'd2, 6'd1), 32'h0, 1'b0);
    runCmd(START, 1'b0, 0, ts, tc, td, rx, rb);
    runCmd(DBIT, 1'b1, 4, ts, tc, td, rx, rb);
    check("R7 scl release index with stretch", tc, 6);
    check("R7 bit done index with stretch", td, 13);

    // R8: received bit follows sensed SDA at the end of SCL high
    slaveSdaLow = 1'b1;
    runCmd(DBIT, 1'b1, 0, ts, tc, td, rx, rb);
    slaveSdaLow = 1'b0;
    check("R8 rxBit with slave pulling low", rx, 0);
    runCmd(DBIT, 1'b1, 0, ts, tc, td, rx, rb);
    check("R8 rxBit with line released", rx, 1);

    // R12: START while SCL is held is dropped
    pulseCmd(START);
    sawDone = 0;
    for (int i = 0; i < 12; i++) begin
      if (doneStrobe) sawDone = 1;
      @(negedge clk);
    end
    check("R12 no done after START in held state", sawDone, 0);
    check("R12 lines held after ignored START", {sclLow, sdaLow}, 2'b10);
    runCmd(STOP, 1'b0, 0, ts, tc, td, rx, rb);

    // R12: a data bit while idle is dropped
    pulseCmd(DBIT);
    sawDone = 0;
    for (int i = 0; i < 12; i++) begin
      if (doneStrobe || sclLow || sdaLow) sawDone = 1;
      @(negedge clk);
    end
    check("R12 no activity after bit in idle", sawDone, 0);
    check("R12 R13 still ready in idle", cmdReady, 1);

    // R1: disabling while SCL is held releases both lines
    runCmd(START, 1'b0, 0, ts, tc, td, rx, rb);
    enable = 1'b0;
    @(negedge clk);
    check("R1 lines released after disable", {sclLow, sdaLow}, 0);
    check("R1 ready low after disable", cmdReady, 0);

    // R11: filter widths captured while disabled
    filtCfg = 32'h0A05_0000;
    repeat (2) @(negedge clk);
    check("R11 scl filter field", sclFilt, 4'h5);
    check("R11 sda filter field", sdaFilt, 4'hA);

    // R9: high-speed word selected by hsMode
    setup(3'd0, mkWord(6'd5, 6'd2, 6'd2, 6'd1), mkWord(6'd1, 6'd1, 6'd0, 6'd0), 1'b1);
    runCmd(START, 1'b0, 0, ts, tc, td, rx, rb);
    check("R9 start done with hs word", td, 1);
    runCmd(DBIT, 1'b1, 0, ts, tc, td, rx, rb);
    check("R9 bit done with hs word", td, 4);

    // R10: changes while enabled do not take effect
    hsMode = 1'b0;
    timingHs = mkWord(6'd5, 6'd5, 6'd5, 6'd5);
    prescale = 3'd3;
    filtCfg = 32'h0307_0000;
    runCmd(STOP, 1'b0, 0, ts, tc, td, rx, rb);
    check("R10 stop done unchanged", td, 3);
    runCmd(START, 1'b0, 0, ts, tc, td, rx, rb);
    check("R10 start done unchanged", td, 1);
    check("R10 scl filter unchanged", sclFilt, 4'h5);
    check("R10 sda filter unchanged", sdaFilt, 4'hA);
    runCmd(STOP, 1'b0, 0, ts, tc, td, rx, rb);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule